// File: doc/BRIEF.md
# Checksummed Text Command Frame Receiver

This block sits behind a byte-wide serial receiver and turns its byte stream into text command frames. A frame is a run of command characters, a colon, a checksum of exactly two hexadecimal characters, and then a carriage return (0x0D) and a line feed (0x0A). While the command characters arrive, the block adds them into an 8-bit running total, which wraps modulo 256. It stores the characters in a small buffer. When the frame ends, it compares the total with the received checksum.

Each frame ends on a line feed. At that point the block raises a single-cycle completion strobe and presents a status code and the command length. The stored command characters can be read back through a synchronous read port. Any byte sequence that breaks the grammar is reported as malformed. Reception then picks up again after the next line feed, so the following frame is parsed cleanly.

Top module: `cmd_frame_rx`

## Requirements
- R1: The command characters of a frame (all bytes before the first colon) are written to the text buffer at addresses 0 upward. `rd_data` returns the byte at `rd_addr` one clock after the address is applied. The text stays readable until the first command byte of the next frame arrives.
- R2: The expected checksum is the sum of the command bytes modulo 256. The first hex character is the high nibble. If the received value equals the expected checksum, the status is 0 (good) and `cmd_len` is the number of command bytes. If the two differ, the status is 1 (bad checksum), with the same length.
- R3: The checksum digits accept 0-9, A-F and a-f, and upper and lower case give the same value.
- R4: A frame that has no command characters before the colon gets status 2 (empty), with `cmd_len` 0, whatever its checksum field holds.
- R5: A checksum field that has a character other than a hex digit, or that is shorter than two characters, gets status 3 (malformed), with `cmd_len` 0.
- R6: Up to `MAX_LEN` (32) command characters are accepted. If a further character arrives before the colon, the frame is malformed and every byte up to the next line feed is discarded.
- R7: A line feed with no carriage return just before it, a carriage return followed by anything other than a line feed, and a carriage return inside the command text each make the frame malformed. The next frame after the line feed is still parsed normally.
- R8: `frame_done` is high for exactly the cycle after the clock edge that accepts a frame's line feed. `frame_status` and `cmd_len` change only in that cycle and otherwise hold their values. Two back-to-back line feeds give strobes on two consecutive cycles.
- R9: A byte presented with `in_valid` low has no effect, even if it is a line feed.
- R10: A synchronous reset discards any partial frame and clears the running sum. After reset, `frame_done` is 0, `frame_status` is 0 and `cmd_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_data` holds a received byte this cycle |
| in_data | input | 8 | Received byte |
| frame_done | output | 1 | One-cycle strobe at the end of each frame |
| frame_status | output | 2 | 0 good, 1 bad checksum, 2 empty, 3 malformed |
| cmd_len | output | 6 | Command length of the last frame (0 unless status is 0 or 1) |
| rd_addr | input | 5 | Text buffer read address |
| rd_data | output | 8 | Text buffer byte, one cycle after `rd_addr` |

## Verification
The hardest situations to reach are the exact length boundary and the resynchronisation paths. Reaching the boundary needs a frame of exactly 32 command characters with a correct checksum, and its 33-character neighbour. Reaching resynchronisation needs a frame to fail partway through its trailer (a stray byte between CR and LF, or a bare LF) and then a good frame to follow. The stimulus builds these frames programmatically, interleaves idle cycles that carry line-feed values on the data bus with `in_valid` low, and places a reset in the middle of a partial frame. A behavioural model evaluates each complete line as a whole and compares the outputs every clock.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  typedef enum logic [1:0] {
    CFR_OK        = 2'd0,
    CFR_BADSUM    = 2'd1,
    CFR_EMPTY     = 2'd2,
    CFR_MALFORMED = 2'd3
  } cfr_status_t;

  typedef enum logic [2:0] {
    S_TEXT, S_HI, S_LO, S_CR, S_LF, S_SKIP
  } cfr_state_t;

  localparam logic [7:0] CH_COLON = 8'h3A;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;
endpackage

// File: rtl/cfr_hex_nib.sv
module cfr_hex_nib (
  input  logic [7:0] ch,
  output logic       ok,
  output logic [3:0] nib
);
  always_comb begin
    ok  = 1'b1;
    nib = 4'd0;
    if (ch >= 8'h30 && ch <= 8'h39)      nib = 4'(ch - 8'h30);
    else if (ch >= 8'h41 && ch <= 8'h46) nib = 4'(ch - 8'h37);
    else if (ch >= 8'h61 && ch <= 8'h66) nib = 4'(ch - 8'h57);
    else                                 ok  = 1'b0;
  end
endmodule

// File: rtl/cfr_text_buf.sv
module cfr_text_buf #(
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic [AW-1:0] ra,
  output logic [7:0]    rd
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/cfr_parser.sv
module cfr_parser
  import cfr_pkg::*;
#(
  parameter  int MAX_LEN = 32,
  localparam int AW      = $clog2(MAX_LEN),
  localparam int LW      = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          frame_done,
  output cfr_status_t   frame_status,
  output logic [LW-1:0] cmd_len
);
  cfr_state_t    st, nxt;
  logic [7:0]    sum;
  logic [LW-1:0] cnt;
  logic [3:0]    hi_nib;
  logic          match;
  logic          hex_ok;
  logic [3:0]    hex_val;
  logic          store, fin, take_hi, take_lo;
  cfr_status_t   fin_stat;

  cfr_hex_nib u_hex (.ch(in_data), .ok(hex_ok), .nib(hex_val));

  always_comb begin
    nxt      = st;
    store    = 1'b0;
    fin      = 1'b0;
    take_hi  = 1'b0;
    take_lo  = 1'b0;
    fin_stat = CFR_MALFORMED;
    if (in_valid) begin
      if (in_data == CH_LF && st != S_LF) begin
        fin = 1'b1;
      end else begin
        case (st)
          S_TEXT:
            if (in_data == CH_COLON) nxt = S_HI;
            else if (in_data == CH_CR || cnt == LW'(MAX_LEN)) nxt = S_SKIP;
            else store = 1'b1;
          S_HI:
            if (hex_ok) begin take_hi = 1'b1; nxt = S_LO; end
            else nxt = S_SKIP;
          S_LO:
            if (hex_ok) begin take_lo = 1'b1; nxt = S_CR; end
            else nxt = S_SKIP;
          S_CR:
            nxt = (in_data == CH_CR) ? S_LF : S_SKIP;
          S_LF:
            if (in_data == CH_LF) begin
              fin = 1'b1;
              if (cnt == '0)  fin_stat = CFR_EMPTY;
              else if (match) fin_stat = CFR_OK;
              else            fin_stat = CFR_BADSUM;
            end else nxt = S_SKIP;
          default: nxt = S_SKIP;
        endcase
      end
      if (fin) nxt = S_TEXT;
    end
  end

  assign wr_en   = store;
  assign wr_addr = cnt[AW-1:0];
  assign wr_data = in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_TEXT;
      sum          <= '0;
      cnt          <= '0;
      hi_nib       <= '0;
      match        <= 1'b0;
      frame_done   <= 1'b0;
      frame_status <= CFR_OK;
      cmd_len      <= '0;
    end else begin
      frame_done <= fin;
      st         <= nxt;
      if (store) begin
        sum <= sum + in_data;
        cnt <= cnt + 1'b1;
      end
      if (take_hi) hi_nib <= hex_val;
      if (take_lo) match  <= ({hi_nib, hex_val} == sum);
      if (fin) begin
        frame_status <= fin_stat;
        cmd_len      <= (fin_stat == CFR_OK || fin_stat == CFR_BADSUM) ? cnt : '0;
        sum          <= '0;
        cnt          <= '0;
        match        <= 1'b0;
      end
    end
  end

  // R6: the stored length never exceeds the buffer size
  p_len_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= LW'(MAX_LEN));

  // R8: outputs only move in a strobe cycle
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!frame_done && !$past(rst)) |-> ($stable(frame_status) && $stable(cmd_len)));

  // R2: a good frame always carries command text
  p_ok_len_r2: assert property (@(posedge clk) disable iff (rst)
    (frame_done && frame_status == CFR_OK) |-> cmd_len != '0);

  // R5: malformed and empty frames report no length
  p_bad_frame_len_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_done && (frame_status == CFR_MALFORMED || frame_status == CFR_EMPTY)) |-> cmd_len == '0);

  // R9: without a valid byte the parser state does not move
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(st));
endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx #(
  parameter  int MAX_LEN = 32,
  localparam int AW      = $clog2(MAX_LEN),
  localparam int LW      = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          frame_done,
  output logic [1:0]    frame_status,
  output logic [LW-1:0] cmd_len,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic                 wr_en;
  logic [AW-1:0]        wr_addr;
  logic [7:0]           wr_data;
  cfr_pkg::cfr_status_t stat;

  cfr_parser #(.MAX_LEN(MAX_LEN)) u_parser (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_done(frame_done), .frame_status(stat), .cmd_len(cmd_len)
  );

  cfr_text_buf #(.DEPTH(MAX_LEN)) u_buf (
    .clk(clk), .we(wr_en), .wa(wr_addr), .wd(wr_data),
    .ra(rd_addr), .rd(rd_data)
  );

  assign frame_status = stat;
endmodule

// File: tb/test_cmd_frame_rx.sv
module test_cmd_frame_rx;
  localparam int MAXL = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h0A;
  logic       frame_done;
  logic [1:0] frame_status;
  logic [5:0] cmd_len;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  string cur_tag = "R10";

  always #2.5 clk = ~clk;

  cmd_frame_rx i_cmd_frame_rx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .frame_done(frame_done), .frame_status(frame_status), .cmd_len(cmd_len),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // behavioural model: collect a line, judge it whole at its line feed
  byte unsigned q[$];
  bit  exp_done = 0;
  int  exp_stat = 0;
  int  exp_len  = 0;
  bit  started  = 0;

  function automatic bit is_hex(byte unsigned c);
    return (c >= "0" && c <= "9") || (c >= "A" && c <= "F") || (c >= "a" && c <= "f");
  endfunction

  function automatic int hex_val(byte unsigned c);
    if (c <= "9") return c - "0";
    if (c <= "F") return c - "A" + 10;
    return c - "a" + 10;
  endfunction

  task automatic judge_line();
    int ci = -1;
    bit mal;
    int s = 0;
    for (int i = 0; i < q.size(); i++)
      if (q[i] == 8'h3A || q[i] == 8'h0D) begin ci = i; break; end
    mal = (ci < 0);
    if (!mal) mal = (q[ci] == 8'h0D) || (ci > MAXL) || (q.size() != ci + 4);
    if (!mal) mal = !is_hex(q[ci+1]) || !is_hex(q[ci+2]) || (q[ci+3] != 8'h0D);
    if (mal) begin exp_stat = 3; exp_len = 0; end
    else if (ci == 0) begin exp_stat = 2; exp_len = 0; end
    else begin
      for (int i = 0; i < ci; i++) s += q[i];
      exp_len  = ci;
      exp_stat = ((s % 256) == hex_val(q[ci+1]) * 16 + hex_val(q[ci+2])) ? 0 : 1;
    end
  endtask

  always @(posedge clk) begin
    exp_done = 0;
    if (rst) begin
      q.delete();
      exp_stat = 0;
      exp_len  = 0;
    end else if (in_valid) begin
      if (in_data == 8'h0A) begin
        judge_line();
        exp_done = 1;
        q.delete();
      end else q.push_back(in_data);
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started) begin
      total++;
      if (frame_done !== exp_done || frame_status !== 2'(exp_stat) || cmd_len !== 6'(exp_len)) begin
        bad++;
        $display("FAIL %s: done=%0b/%0b status=%0d/%0d len=%0d/%0d (actual/expected)",
                 cur_tag, frame_done, exp_done, frame_status, exp_stat, cmd_len, exp_len);
      end
    end
  end

  task automatic put(byte unsigned b, int gap = 0);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 8'h0A;
    repeat (gap) @(negedge clk);
  endtask

  task automatic put_str(string s, int gap = 0);
    for (int i = 0; i < s.len(); i++) put(s[i], gap);
  endtask

  task automatic frame(string s, string tag, int gap = 0);
    cur_tag = tag;
    put_str(s, gap);
    put(8'h0D, gap);
    put(8'h0A, gap);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_text(string s);
    for (int i = 0; i < s.len(); i++) begin
      rd_addr = 5'(i);
      @(negedge clk);
      total++;
      if (rd_data !== s[i]) begin
        bad++;
        $display("FAIL R1: text[%0d]=%h expected %h", i, rd_data, s[i]);
      end
    end
  endtask

  initial begin
    string longs;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    frame("VER", "R2");
    check_text("VER");
    frame("ERRLOG", "R2");
    check_text("ERRLOG");
    frame("DATE", "R2");
    frame("VER:ED", "R2");
    frame("VER:EE", "R2");
    frame("DATE:1e", "R3");
    frame("ERRLOG:cB", "R3");
    frame(":00", "R4");
    frame(":5A", "R4");
    frame("VER:G1", "R5");
    frame("VER:E", "R5");
    frame("VER:EDX", "R5");

    longs = "";
    for (int i = 0; i < MAXL; i++) longs = {longs, "A"};
    frame({longs, ":20"}, "R6");
    check_text(longs);
    frame({longs, "B:61"}, "R6");
    frame("VER:ED", "R6");

    cur_tag = "R7";
    put_str("VER:ED"); put(8'h0A); repeat (2) @(negedge clk);
    put_str("VER:ED"); put(8'h0D); put("X"); put(8'h0A); repeat (2) @(negedge clk);
    put_str("VE"); put(8'h0D); put_str("R:ED"); put(8'h0D); put(8'h0A); repeat (2) @(negedge clk);
    put(8'h0D); put(8'h0A); repeat (2) @(negedge clk);
    frame("VER:ED", "R7");

    frame("ERRLOG:CB", "R9", 2);

    cur_tag = "R8";
    put(8'h0A); put(8'h0A); put_str("DATE:1E"); put(8'h0D); put(8'h0A);
    put_str("VER:ED"); put(8'h0D); put(8'h0A);
    repeat (4) @(negedge clk);

    cur_tag = "R10";
    put_str("VE");
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    frame("R:ED", "R10");
    frame("VER:ED", "R10");
    check_text("VER");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule